// File: doc/BRIEF.md
# CAS-Before-RAS Refresh Injector

This block sits on the strobe path between a memory/video controller and a bank of page-mode DRAM modules. It watches the controller's active-low row and column strobes, the active-low horizontal and vertical sync signals and the bus phase clock `e`. From these it sorts every memory slot into one of three kinds: a processor access, a display fetch, or an idle slot. Processor and display slots reach the DRAM unchanged. An idle slot that starts while either sync is active becomes a CAS-before-RAS refresh. The controller's row strobe drives the DRAM column pin and its column strobe drives the DRAM row pin. The column pulse is trimmed so that it ends in the same cycle as the row pulse. The DRAM then refreshes a row from its own internal counter.

The block also widens the address. Two bank-select bits share the top DRAM address line with the controller's own top bit. This lets the memory grow past the controller's native size. All inputs are assumed synchronous to `clk`. Every output is registered and follows its inputs with one clock of latency.

The slot controller has seven named states. `ST_IDLE` means no strobe is low. `ST_CPU` is entered when the row strobe falls while `e` is high. `ST_VIDEO` is entered when the row strobe falls with `e` low and both syncs inactive. `ST_RF_ARM` is entered when a strobe falls during a sync and neither earlier rule applies. `ST_OTHER` is entered when only the column strobe falls outside any sync. `ST_CPU`, `ST_VIDEO` and `ST_OTHER` return to `ST_IDLE` once both strobes are high. The refresh states run `ST_RF_ARM` to `ST_RF_HOLD` (column strobe low), then to `ST_RF_TAIL` (column strobe high again), then to `ST_IDLE` (both high). Any refresh state also drops straight back to `ST_IDLE` if both strobes go high.

Top module: `cbr_refresh_injector`

## Requirements
- R1: While `rst_n` is low, `dram_ras_n` and `dram_cas_n` are 1 and `mem_addr` is 0.
- R2: A slot whose first strobe edge is a fall of `ras_n` with `e`=1 is a processor slot. This holds even during a sync. Both strobes pass through unswapped.
- R3: A slot whose first edge is a fall of `ras_n` with `e`=0 and `hsync_n`=`vsync_n`=1 is a display slot. Both strobes pass through unswapped.
- R4: A slot that starts with `e`=0 while `hsync_n`=0 is a refresh slot. Here `dram_cas_n` follows `ras_n` and `dram_ras_n` follows `cas_n`.
- R5: In a refresh slot, once `cas_n` has been low and returns high, `dram_cas_n` is 1 from the same cycle in which `dram_ras_n` returns to 1.
- R6: A slot that starts with `e`=0 while `vsync_n`=0 is also a refresh slot, with the same swap as R4.
- R7: The slot kind is fixed at the first strobe edge of the slot. A sync that asserts mid-slot does not start a refresh. A sync that deasserts mid-refresh does not end it.
- R8: A slot that begins with only `cas_n` falling outside any sync passes through unswapped.
- R9: `mem_addr[ADDR_W-1]` depends on the strobe phase. It carries `bank_sel[0]` in the row phase (`ras_n`=0, `cas_n`=1) and `bank_sel[1]` in the column phase (`cas_n`=0). Otherwise it carries `addr_in[ADDR_W-1]`. The lower bits always carry `addr_in`.
- R10: Every output reflects the inputs sampled at the previous rising edge of `clk`. It does not change before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset |
| ras_n | input | 1 | Controller row strobe, active low |
| cas_n | input | 1 | Controller column strobe, active low |
| hsync_n | input | 1 | Horizontal sync, active low |
| vsync_n | input | 1 | Vertical sync, active low |
| e | input | 1 | Bus phase clock, high in processor phase |
| addr_in | input | ADDR_W | Controller multiplexed address |
| bank_sel | input | 2 | Extra bank bits, [0] in row phase, [1] in column phase |
| dram_ras_n | output | 1 | Row strobe to DRAM |
| dram_cas_n | output | 1 | Column strobe to DRAM |
| mem_addr | output | ADDR_W | Address to DRAM |

## Verification
Every strobe and address result is due exactly one rising clock edge after the inputs that cause it. The bench changes inputs on a falling edge and compares on the next falling edge, half a period after the edge that registers them. One check samples just before that rising edge to confirm that nothing has moved yet. The refresh model follows each slot step by step. It computes the swapped and trimmed strobes from the input pair and from whether the column strobe has already pulsed in that slot.

// File: rtl/cbr_pkg.sv
package cbr_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_CPU     = 3'd1,
        ST_VIDEO   = 3'd2,
        ST_OTHER   = 3'd3,
        ST_RF_ARM  = 3'd4,
        ST_RF_HOLD = 3'd5,
        ST_RF_TAIL = 3'd6
    } slot_st_t;

    localparam int PHASES = 2;
endpackage

// File: rtl/cbr_sampler.sv
module cbr_sampler
    import cbr_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [PHASES-1:0] bank_sel,
    output logic              ras_q,
    output logic              cas_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [PHASES-1:0] bank_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ras_q  <= 1'b1;
            cas_q  <= 1'b1;
            addr_q <= '0;
            bank_q <= '0;
        end else begin
            ras_q  <= ras_n;
            cas_q  <= cas_n;
            addr_q <= addr_in;
            bank_q <= bank_sel;
        end
    end
endmodule

// File: rtl/cbr_slot_fsm.sv
module cbr_slot_fsm
    import cbr_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     ras_n,
    input  logic     cas_n,
    input  logic     hsync_n,
    input  logic     vsync_n,
    input  logic     e,
    output slot_st_t st
);
    slot_st_t nxt;
    logic     in_sync;
    logic     both_high;

    assign in_sync   = !hsync_n || !vsync_n;
    assign both_high = ras_n && cas_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE: begin
                if (!ras_n && e)                         nxt = ST_CPU;
                else if (!ras_n && !in_sync)             nxt = ST_VIDEO;
                else if (!both_high && in_sync)          nxt = ST_RF_ARM;
                else if (!cas_n)                         nxt = ST_OTHER;
            end
            ST_CPU, ST_VIDEO, ST_OTHER: begin
                if (both_high) nxt = ST_IDLE;
            end
            ST_RF_ARM: begin
                if (both_high)   nxt = ST_IDLE;
                else if (!cas_n) nxt = ST_RF_HOLD;
            end
            ST_RF_HOLD: begin
                if (both_high)  nxt = ST_IDLE;
                else if (cas_n) nxt = ST_RF_TAIL;
            end
            ST_RF_TAIL: begin
                if (both_high) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // R2: processor slots are entered only with e high at the first edge
    p_cpu_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_CPU && $past(st) == ST_IDLE) |-> $past(e));

    // R4 / R6: refresh is entered only while a sync is active
    p_refresh_in_sync_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RF_ARM && $past(st) == ST_IDLE) |-> (!$past(hsync_n) || !$past(vsync_n)));

    // R7: a pass-through slot never turns into a refresh mid-slot
    p_kind_latched_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st) == ST_VIDEO || $past(st) == ST_CPU || $past(st) == ST_OTHER)
            |-> (st == $past(st) || st == ST_IDLE));
endmodule

// File: rtl/cbr_drive.sv
module cbr_drive
    import cbr_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  slot_st_t          st,
    input  logic              ras_q,
    input  logic              cas_q,
    input  logic [ADDR_W-1:0] addr_q,
    input  logic [PHASES-1:0] bank_q,
    output logic              dram_ras_n,
    output logic              dram_cas_n,
    output logic [ADDR_W-1:0] mem_addr
);
    localparam int TOP = ADDR_W - 1;

    logic refreshing;
    assign refreshing = (st == ST_RF_ARM) || (st == ST_RF_HOLD) || (st == ST_RF_TAIL);

    always_comb begin
        if (refreshing) begin
            dram_ras_n = cas_q;
            dram_cas_n = (st == ST_RF_TAIL) ? 1'b1 : ras_q;
        end else begin
            dram_ras_n = ras_q;
            dram_cas_n = cas_q;
        end
    end

    always_comb begin
        mem_addr = addr_q;
        if (!cas_q)      mem_addr[TOP] = bank_q[1];
        else if (!ras_q) mem_addr[TOP] = bank_q[0];
    end
endmodule

// File: rtl/cbr_refresh_injector.sv
module cbr_refresh_injector
    import cbr_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              hsync_n,
    input  logic              vsync_n,
    input  logic              e,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [1:0]        bank_sel,
    output logic              dram_ras_n,
    output logic              dram_cas_n,
    output logic [ADDR_W-1:0] mem_addr
);
    logic              ras_q, cas_q;
    logic [ADDR_W-1:0] addr_q;
    logic [1:0]        bank_q;
    slot_st_t          st;

    cbr_sampler #(.ADDR_W(ADDR_W)) u_smp (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n),
        .addr_in(addr_in), .bank_sel(bank_sel),
        .ras_q(ras_q), .cas_q(cas_q), .addr_q(addr_q), .bank_q(bank_q)
    );

    cbr_slot_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n),
        .hsync_n(hsync_n), .vsync_n(vsync_n), .e(e), .st(st)
    );

    cbr_drive #(.ADDR_W(ADDR_W)) u_drv (
        .st(st), .ras_q(ras_q), .cas_q(cas_q), .addr_q(addr_q), .bank_q(bank_q),
        .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .mem_addr(mem_addr)
    );

    // R2 / R3: pass-through slots copy the previous-cycle strobes
    p_pass_through_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_CPU || st == ST_VIDEO || st == ST_OTHER)
            |-> (dram_ras_n == $past(ras_n) && dram_cas_n == $past(cas_n)));

    // R4: while armed or holding, the DRAM row pin follows the column input
    p_swap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RF_ARM || st == ST_RF_HOLD) |-> (dram_ras_n == $past(cas_n)));

    // R5: the column pulse ends no later than the row pulse in a refresh
    p_trim_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st) == ST_RF_HOLD && dram_ras_n) |-> dram_cas_n);
endmodule

// File: tb/sim_cbr_refresh_injector.sv
module sim_cbr_refresh_injector;
    localparam int AW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ras_n = 1'b1, cas_n = 1'b1, hsync_n = 1'b1, vsync_n = 1'b1, e = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic [1:0]    bank_sel = '0;
    logic          dram_ras_n, dram_cas_n;
    logic [AW-1:0] mem_addr;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit saw_c;

    always #5 clk = ~clk;

    cbr_refresh_injector #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n),
        .hsync_n(hsync_n), .vsync_n(vsync_n), .e(e),
        .addr_in(addr_in), .bank_sel(bank_sel),
        .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .mem_addr(mem_addr)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // one slot step: drive at a falling edge, compare at the next one
    task automatic step(input logic r, input logic c, input bit refr, input string tag);
        logic xr, xc;
        ras_n = r; cas_n = c;
        @(negedge clk);
        if (refr) begin
            if (!c) saw_c = 1;
            xr = c;
            xc = (saw_c && c) ? 1'b1 : r;
        end else begin
            xr = r; xc = c;
        end
        chk({31'd0, dram_ras_n}, {31'd0, xr}, {tag, " ras"});
        chk({31'd0, dram_cas_n}, {31'd0, xc}, {tag, " cas"});
    endtask

    task automatic slot(input bit refr, input string tag);
        saw_c = 0;
        step(0, 1, refr, tag);
        step(0, 0, refr, tag);
        step(0, 1, refr, tag);
        step(1, 1, refr, tag);
    endtask

    task automatic t_reset();
        chk({31'd0, dram_ras_n}, 32'd1, "R1 ras");
        chk({31'd0, dram_cas_n}, 32'd1, "R1 cas");
        chk({22'd0, mem_addr}, 32'd0, "R1 addr");
    endtask

    task automatic t_cpu();
        e = 1; hsync_n = 0;
        slot(0, "R2 cpu in hsync");
        e = 0; hsync_n = 1;
    endtask

    task automatic t_video();
        slot(0, "R3 video");
    endtask

    task automatic t_hsync_refresh();
        hsync_n = 0;
        slot(1, "R4 R5 hsync refresh");
        hsync_n = 1;
    endtask

    task automatic t_vsync_refresh();
        vsync_n = 0;
        slot(1, "R6 vsync refresh");
        vsync_n = 1;
    endtask

    task automatic t_latch();
        saw_c = 0;
        step(0, 1, 0, "R7 video start");
        hsync_n = 0;
        step(0, 0, 0, "R7 sync late");
        step(0, 1, 0, "R7 sync late");
        hsync_n = 1;
        step(1, 1, 0, "R7 sync late");
        saw_c = 0;
        vsync_n = 0;
        step(0, 1, 1, "R7 refresh start");
        vsync_n = 1;
        step(0, 0, 1, "R7 sync drop");
        step(0, 1, 1, "R7 sync drop");
        step(1, 1, 1, "R7 sync drop");
    endtask

    task automatic t_cas_first();
        saw_c = 0;
        step(1, 0, 0, "R8 cas first");
        step(0, 0, 0, "R8 cas first");
        step(1, 1, 0, "R8 cas first");
    endtask

    task automatic t_addr();
        addr_in = 10'h155; bank_sel = 2'b01;
        e = 1;
        ras_n = 0; cas_n = 1;
        @(negedge clk);
        chk({22'd0, mem_addr}, 32'h355, "R9 row phase bank0");
        ras_n = 0; cas_n = 0;
        @(negedge clk);
        chk({22'd0, mem_addr}, 32'h155, "R9 col phase bank1");
        bank_sel = 2'b10;
        @(negedge clk);
        chk({22'd0, mem_addr}, 32'h355, "R9 col phase bank1 set");
        ras_n = 1; cas_n = 1; addr_in = 10'h2AA;
        @(negedge clk);
        chk({22'd0, mem_addr}, 32'h2AA, "R9 idle normal bit");
        e = 0;
    endtask

    task automatic t_latency();
        ras_n = 0; cas_n = 1; e = 1;
        #3;
        chk({31'd0, dram_ras_n}, 32'd1, "R10 before edge");
        @(negedge clk);
        chk({31'd0, dram_ras_n}, 32'd0, "R10 after edge");
        ras_n = 1;
        @(negedge clk);
        chk({31'd0, dram_ras_n}, 32'd1, "R10 release");
        e = 0;
    endtask

    initial begin
        #500000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_cpu();
        t_video();
        t_hsync_refresh();
        t_vsync_refresh();
        t_latch();
        t_cas_first();
        t_addr();
        t_latency();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule